// File: doc/BRIEF.md
# Clause Literal-Count Register Bank

This block keeps, for every clause of a conjunctive Boolean formula, a small register that records how many of the clause's literals the current variable assignment makes true. A clause counts as satisfied while its register is nonzero. The block is fed one variable at a time: each cycle it may receive that variable's clause-membership word (two bits per clause, read from an external memory) together with the variable's current value, plus an operation code.

Three operations act on the bank. A load adds the variable's true literals into the counts and is used to build the counts for a fresh assignment, one variable after another. A flip moves the counts to reflect that one variable has changed value. An evaluate leaves the counts untouched and computes the signed net change in satisfied clauses that flipping the variable would cause, which a local-search controller uses to pick the best variable to flip. The block reports the number of satisfied clauses on a registered output, and a synchronous clear empties every counter before a new attempt.

Top module: `clb_bank`

## Requirements
- R1: The membership word holds one bit pair per clause, with clause i at bits [2i+1:2i]. Bit 2i+1 set means the variable appears in clause i. Bit 2i gives the value that satisfies it (11 is a positive literal, 10 a negated one). A pair with bit 2i+1 clear (00 or 01) leaves clause i alone under every operation.
- R2: The op input selects 00 idle, 01 load, 10 flip, 11 evaluate. On a load, every clause whose literal is true under varValue gains one in its count, and no count falls.
- R3: On a flip, varValue is the value before the flip. Each clause whose literal was true loses one from its count. Each clause where the variable appears with the other polarity gains one.
- R4: Each count runs from 0 to MAX_LITS and saturates at both ends. An increment at MAX_LITS and a decrement at 0 leave the count unchanged.
- R5: On an evaluate, gain takes the number of clauses that would go from count 0 to 1, minus the number that would go from 1 to 0. It is a two's-complement value of width GAIN_W, visible after the same clock edge. No count changes.
- R6: gain holds its value in every cycle whose op is not evaluate.
- R7: satTotal is the number of clauses with a nonzero count. It is registered, so it shows a counter update one clock edge after the edge that made the update.
- R8: A high clear empties every count on the next edge and wins over any op given in the same cycle. It does not change gain.
- R9: An active-low asynchronous reset sets every count, satTotal and gain to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all counts |
| op | input | 2 | Operation: idle, load, flip, evaluate |
| memWord | input | 2*NUM_CLAUSES | Clause-membership word of the current variable |
| varValue | input | 1 | Current value of that variable |
| satTotal | output | CNT_W | Registered count of satisfied clauses |
| gain | output | GAIN_W | Signed flip gain from the last evaluate |

## Verification
The bench builds the bank with NUM_CLAUSES = 8 and MAX_LITS = 5. The word is then 16 bits wide and gain is 5 bits wide, so an all-clauses word pushes gain to its extremes of -8 and +8. Seven repeated loads of one word also drive every counter into saturation. The random phase uses five variables, so no clause can hold more than five literals. This keeps the counts exact, and both the gain and the total can be compared with a direct evaluation of the formula under each assignment.

// File: rtl/clb_pkg.sv
package clb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LOAD = 2'b01,
    OP_FLIP = 2'b10,
    OP_EVAL = 2'b11
  } clbOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic load;
    logic flip;
    logic eval;
  } clbStrobe_t;

endpackage

// File: rtl/clb_clause_cell.sv
// One clause: thermometer count of true literals, saturating at both ends.
module clb_clause_cell #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic up,
  input  logic down,
  output logic nonZero,
  output logic isOne
);

  logic [DEPTH-1:0] therm;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              therm <= '0;
        else if (clr)            therm <= '0;
        else if (up && !down)    therm <= 1'b1;
        else if (down && !up)    therm <= 1'b0;
      end
      assign isOne = therm[0];
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              therm <= '0;
        else if (clr)            therm <= '0;
        else if (up && !down)    therm <= {therm[DEPTH-2:0], 1'b1};
        else if (down && !up)    therm <= {1'b0, therm[DEPTH-1:1]};
      end
      assign isOne = therm[0] & ~therm[1];
    end
  endgenerate

  assign nonZero = therm[0];

endmodule

// File: rtl/clb_control.sv
// Decodes clear and op into datapath strobes; clear dominates.
module clb_control
  import clb_pkg::*;
(
  input  logic       clear,
  input  logic [1:0] op,
  output clbStrobe_t strobe
);

  clbOp_e opDec;

  always_comb begin
    opDec        = clbOp_e'(op);
    strobe       = '0;
    strobe.clr   = clear;
    if (!clear) begin
      unique case (opDec)
        OP_LOAD: strobe.load = 1'b1;
        OP_FLIP: strobe.flip = 1'b1;
        OP_EVAL: strobe.eval = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/clb_datapath.sv
module clb_datapath
  import clb_pkg::*;
#(
  parameter int NUM_CLAUSES = 8,
  parameter int MAX_LITS    = 5,
  parameter int CNT_W       = 4,
  parameter int GAIN_W      = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  clbStrobe_t                    strobe,
  input  logic [2*NUM_CLAUSES-1:0]      memWord,
  input  logic                          varValue,
  output logic [CNT_W-1:0]              satTotal,
  output logic signed [GAIN_W-1:0]      gain
);

  logic [NUM_CLAUSES-1:0] litTrue;
  logic [NUM_CLAUSES-1:0] litFalse;
  logic [NUM_CLAUSES-1:0] upVec;
  logic [NUM_CLAUSES-1:0] downVec;
  logic [NUM_CLAUSES-1:0] nonZeroVec;
  logic [NUM_CLAUSES-1:0] isOneVec;
  logic [NUM_CLAUSES-1:0] risingVec;
  logic [NUM_CLAUSES-1:0] fallingVec;

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_CLAUSES-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_CLAUSES; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  generate
    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
      logic present;
      logic polarity;
      assign present     = memWord[2*c+1];
      assign polarity    = memWord[2*c];
      assign litTrue[c]  = present & (polarity == varValue);
      assign litFalse[c] = present & (polarity != varValue);
      assign upVec[c]    = (strobe.load & litTrue[c]) | (strobe.flip & litFalse[c]);
      assign downVec[c]  = strobe.flip & litTrue[c];

      clb_clause_cell #(.DEPTH(MAX_LITS)) i_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (strobe.clr),
        .up      (upVec[c]),
        .down    (downVec[c]),
        .nonZero (nonZeroVec[c]),
        .isOne   (isOneVec[c])
      );
    end
  endgenerate

  assign risingVec  = litFalse & ~nonZeroVec;
  assign fallingVec = litTrue & isOneVec;

  logic [CNT_W-1:0]         riseCnt;
  logic [CNT_W-1:0]         fallCnt;
  logic signed [GAIN_W-1:0] gainNext;

  always_comb begin
    riseCnt  = popCount(risingVec);
    fallCnt  = popCount(fallingVec);
    gainNext = $signed({1'b0, riseCnt}) - $signed({1'b0, fallCnt});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      satTotal <= '0;
      gain     <= '0;
    end else begin
      satTotal <= popCount(nonZeroVec);
      if (strobe.eval) gain <= gainNext;
    end
  end

endmodule

// File: rtl/clb_bank.sv
module clb_bank
  import clb_pkg::*;
#(
  parameter  int NUM_CLAUSES = 8,
  parameter  int MAX_LITS    = 5,
  localparam int CNT_W       = $clog2(NUM_CLAUSES + 1),
  localparam int GAIN_W      = CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic [1:0]               op,
  input  logic [2*NUM_CLAUSES-1:0] memWord,
  input  logic                     varValue,
  output logic [CNT_W-1:0]         satTotal,
  output logic signed [GAIN_W-1:0] gain
);

  clbStrobe_t strobe;

  clb_control i_control (
    .clear  (clear),
    .op     (op),
    .strobe (strobe)
  );

  clb_datapath #(
    .NUM_CLAUSES (NUM_CLAUSES),
    .MAX_LITS    (MAX_LITS),
    .CNT_W       (CNT_W),
    .GAIN_W      (GAIN_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .memWord  (memWord),
    .varValue (varValue),
    .satTotal (satTotal),
    .gain     (gain)
  );

endmodule

// File: rtl/clb_bank_chk.sv
module clb_bank_chk #(
  parameter  int NUM_CLAUSES = 8,
  localparam int CNT_W       = $clog2(NUM_CLAUSES + 1),
  localparam int GAIN_W      = CNT_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clear,
  input logic [1:0]               op,
  input logic [CNT_W-1:0]         satTotal,
  input logic signed [GAIN_W-1:0] gain
);

  // R7
  total_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    satTotal <= CNT_W'(NUM_CLAUSES));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> ##2 (satTotal == '0));

  // R5
  eval_keeps_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b11 && !clear) |-> ##2 $stable(satTotal));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b11 || clear) |=> $stable(gain));

  // R5
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain <= GAIN_W'(NUM_CLAUSES)) && (gain >= -$signed(GAIN_W'(NUM_CLAUSES))));

  // R2
  load_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b01 && !clear) |-> ##2 (satTotal >= $past(satTotal)));

endmodule

bind clb_bank clb_bank_chk #(.NUM_CLAUSES(NUM_CLAUSES)) i_clb_bank_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .op       (op),
  .satTotal (satTotal),
  .gain     (gain)
);

// File: tb/test_clb_bank.sv
`timescale 1ns/1ps
module test_clb_bank;

  localparam int NC = 8;
  localparam int ML = 5;
  localparam int CW = $clog2(NC + 1);
  localparam int GW = CW + 1;
  localparam int NV = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 clear = 1'b0;
  logic [1:0]           op = 2'b00;
  logic [2*NC-1:0]      memWord = '0;
  logic                 varValue = 1'b0;
  logic [CW-1:0]        satTotal;
  logic signed [GW-1:0] gain;

  int checkCnt = 0;
  int failCnt  = 0;
  int cnt [NC];
  logic [2*NC-1:0] words [NV];
  logic            asg   [NV];

  always #2.5 clk = ~clk;

  clb_bank #(.NUM_CLAUSES(NC), .MAX_LITS(ML)) i_clb_bank (
    .clk(clk), .rst_n(rst_n), .clear(clear), .op(op),
    .memWord(memWord), .varValue(varValue),
    .satTotal(satTotal), .gain(gain)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelTotal();
    int t = 0;
    for (int i = 0; i < NC; i++) if (cnt[i] > 0) t++;
    return t;
  endfunction

  function automatic int modelGain(input logic [2*NC-1:0] w, input logic v);
    int g = 0;
    for (int i = 0; i < NC; i++) begin
      if (w[2*i+1]) begin
        if (w[2*i] == v && cnt[i] == 1) g--;
        if (w[2*i] != v && cnt[i] == 0) g++;
      end
    end
    return g;
  endfunction

  task automatic modelApply(input logic [1:0] o, input logic [2*NC-1:0] w,
                            input logic v, input logic c);
    for (int i = 0; i < NC; i++) begin
      if (c) cnt[i] = 0;
      else if (w[2*i+1]) begin
        if (o == 2'b01 && w[2*i] == v) cnt[i] = (cnt[i] < ML) ? cnt[i] + 1 : ML;
        if (o == 2'b10) begin
          if (w[2*i] == v) cnt[i] = (cnt[i] > 0) ? cnt[i] - 1 : 0;
          else             cnt[i] = (cnt[i] < ML) ? cnt[i] + 1 : ML;
        end
      end
    end
  endtask

  // direct evaluation of the formula held in words[] under an assignment
  function automatic int directSat(input logic a [NV]);
    int t = 0;
    for (int i = 0; i < NC; i++) begin
      bit s = 0;
      for (int v = 0; v < NV; v++)
        if (words[v][2*i+1] && words[v][2*i] == a[v]) s = 1;
      if (s) t++;
    end
    return t;
  endfunction

  // drive at a falling edge; returns at the falling edge after the active edge
  task automatic doOp(input logic [1:0] o, input logic [2*NC-1:0] w,
                      input logic v, input logic c);
    @(negedge clk);
    op = o; memWord = w; varValue = v; clear = c;
    @(negedge clk);
    op = 2'b00; clear = 1'b0;
    modelApply(o, w, v, c);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int seedDummy;
    int gExp;
    int savedGain;
    seedDummy = $urandom(32'd1357);
    for (int i = 0; i < NC; i++) cnt[i] = 0;

    // R9 reset state, with an op presented during reset
    repeat (3) @(negedge clk);
    op = 2'b01; memWord = '1; varValue = 1'b1;
    @(negedge clk);
    check("R9 total in reset", int'(satTotal), 0);
    check("R9 gain in reset", int'(gain), 0);
    op = 2'b00;
    rst_n = 1'b1;
    settle(); settle();
    check("R9 total after reset", int'(satTotal), 0);

    // R1 clause 0 in the low pair, positive literal
    doOp(2'b01, 16'h0003, 1'b1, 1'b0); settle();
    check("R1 clause0 positive", int'(satTotal), 1);
    // R1 pair 01 is absent
    doOp(2'b01, 16'h0004, 1'b1, 1'b0); settle();
    check("R1 pair 01 absent", int'(satTotal), 1);
    doOp(2'b10, 16'h0004, 1'b0, 1'b0); settle();
    check("R1 pair 01 absent on flip", int'(satTotal), 1);
    // R1 negated literal in clause 2
    doOp(2'b01, 16'h0020, 1'b0, 1'b0); settle();
    check("R1 clause2 negated", int'(satTotal), 2);

    // R5 evaluate: clause0 would fall to zero
    doOp(2'b11, 16'h0003, 1'b1, 1'b0);
    check("R5 gain falling", int'(gain), -1);
    settle();
    check("R5 evaluate keeps total", int'(satTotal), 2);
    // R6 gain holds through a load and a flip
    doOp(2'b01, 16'h0300, 1'b1, 1'b0);
    check("R6 gain held after load", int'(gain), -1);
    doOp(2'b10, 16'h0300, 1'b1, 1'b0); settle();
    check("R6 gain held after flip", int'(gain), -1);
    check("R3 flip down clause4", int'(satTotal), 2);

    // R8 clear wins over a simultaneous load, gain unchanged
    doOp(2'b01, 16'hFFFF, 1'b1, 1'b1); settle();
    check("R8 clear over load", int'(satTotal), 0);
    check("R8 gain untouched", int'(gain), -1);

    // R4 saturation at the top
    for (int k = 0; k < 7; k++) doOp(2'b01, 16'hFFFF, 1'b1, 1'b0);
    settle();
    check("R4 all loaded", int'(satTotal), NC);
    doOp(2'b11, 16'hFFFF, 1'b0, 1'b0);
    check("R5 gain zero when all satisfied", int'(gain), 0);
    for (int k = 0; k < 4; k++) doOp(2'b10, 16'hFFFF, 1'b1, 1'b0);
    settle();
    check("R4 count one left", int'(satTotal), NC);
    doOp(2'b11, 16'hFFFF, 1'b1, 1'b0);
    check("R5 gain minimum", int'(gain), -NC);
    doOp(2'b10, 16'hFFFF, 1'b1, 1'b0); settle();
    check("R4 saturated top drained", int'(satTotal), 0);
    doOp(2'b11, 16'hAAAA, 1'b1, 1'b0);
    check("R5 gain maximum", int'(gain), NC);
    // R4 decrement at zero: negated literals, value 0 => true => down at 0
    doOp(2'b10, 16'hAAAA, 1'b0, 1'b0); settle();
    check("R4 floor no wrap", int'(satTotal), 0);
    doOp(2'b01, 16'hFFFF, 1'b1, 1'b0);
    doOp(2'b10, 16'hFFFF, 1'b1, 1'b0); settle();
    check("R4 floor count stayed zero", int'(satTotal), 0);

    // random phase against the direct formula evaluator
    for (int round = 0; round < 4; round++) begin
      doOp(2'b00, '0, 1'b0, 1'b1);
      for (int v = 0; v < NV; v++) begin
        for (int i = 0; i < NC; i++) begin
          words[v][2*i+1] = ($urandom % 3) != 0;
          words[v][2*i]   = $urandom % 2;
        end
        asg[v] = $urandom % 2;
      end
      for (int v = 0; v < NV; v++) doOp(2'b01, words[v], asg[v], 1'b0);
      settle();
      check("R2 load total vs formula", int'(satTotal), directSat(asg));
      for (int it = 0; it < 30; it++) begin
        logic nxt [NV];
        int v;
        v = $urandom % NV;
        nxt = asg;
        nxt[v] = ~asg[v];
        gExp = directSat(nxt) - directSat(asg);
        doOp(2'b11, words[v], asg[v], 1'b0);
        check("R5 random gain vs formula", int'(gain), gExp);
        savedGain = int'(gain);
        doOp(2'b10, words[v], asg[v], 1'b0);
        asg[v] = ~asg[v];
        settle();
        check("R3 random flip total vs formula", int'(satTotal), directSat(asg));
        check("R7 total vs model", int'(satTotal), modelTotal());
        check("R6 random gain held", int'(gain), savedGain);
      end
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule